// File: doc/BRIEF.md
# Clock Synthesizer Parameter Search Engine

This block searches for the settings of a fractional-free clock synthesizer that come closest to a requested pixel or dot clock. The synthesizer has a reference pre-divider M, a feedback multiplier N, a power-of-two post-divider 2^E and an integer output divider DIV. After those comes an optional fixed divide-by-seven stage, which turns a serial bit clock into a pixel clock. Up to three reference frequencies are presented, each with its own valid bit. On a start pulse the engine clamps the target into its legal window. It then walks the references in index order and runs a nested, constraint-pruned loop over M, N and E. For each candidate it computes DIV and the resulting frequency error.

All arithmetic is done by a single shared restoring divider that produces one quotient bit per cycle. Sequencing is done by one state machine with these states:
- IDLE waits for start.
- SRC qualifies the current reference.
- MLO and MHI compute the M window.
- MCHK bounds M.
- PFD computes the comparison frequency.
- NLO and NHI compute the N window.
- NCHK bounds N and forms the VCO frequency.
- EINIT picks the first exponent.
- ECHK bounds E and applies the shift.
- SEV divides by seven.
- RND computes the rounded DIV.
- OUT computes the output frequency and error.
- CMP compares the candidate with the stored best.
- DONE raises the done flag.

The transitions are:
- IDLE goes to SRC on start.
- SRC goes to MLO for a usable reference, stays in SRC to skip one, and goes to DONE after the last index.
- MLO goes to MHI, and MHI goes to MCHK.
- MCHK goes to PFD, or back to SRC when M is exhausted.
- PFD goes to NLO, NLO goes to NHI, and NHI goes to NCHK.
- NCHK goes to EINIT, or back to MCHK when N is exhausted.
- EINIT goes to ECHK.
- ECHK goes to SEV, or straight to RND in dot-only mode, or back to NCHK when E is exhausted.
- SEV goes to RND, RND goes to OUT, and OUT goes to CMP.
- CMP goes back to ECHK, or to DONE on a zero-error improvement.
- DONE goes to IDLE.

All frequencies share one unit, fixed by the limit parameters: Hz by default.

Top module: `pll_param_search`

## Requirements
- R1: A reference is skipped when its valid bit is low, or when its frequency is below FIN_MIN (12 MHz) or above FIN_MAX (192 MHz). Both bounds are inclusive, so they are accepted.
- R2: M takes every integer from max(1, ceil(Fin/PFD_MAX)) to min(M_LIM, floor(Fin/PFD_MIN)), with PFD_MAX 24 MHz, PFD_MIN 12 MHz and M_LIM 8. The comparison frequency is Fpfd = floor(Fin/M).
- R3: For each M, N runs upward from max(N_LO, ceil(VCO_MIN/Fpfd)) and stops before min(N_HI, floor(VCO_MAX/Fpfd)), with N_LO 60, N_HI 120, VCO_MIN 900 MHz and VCO_MAX 1800 MHz. The VCO frequency is Fvco = Fpfd*N.
- R4: E is tried in the order 0, 1, 2, and the reported E is the exponent, not the divisor. Exponent 0 is left out when Fvco exceeds E0_MAX (1039.5 MHz).
- R5: The intermediate frequency is floor(Fvco/2^E). It is then floor-divided by 7 unless dot_only was high at start.
- R6: DIV = max(1, floor((Fout + floor(T/2))/T)) and error = |floor(Fout/DIV) - T|, where T is the clamped target.
- R7: A candidate replaces the stored best only when its error is strictly smaller, so among equal errors the first one found is kept. The best result is shared by all three references.
- R8: The search ends as soon as a candidate with zero error is stored.
- R9: References are visited in the order ref0, ref1, ref2. sel_src reports the winner as 0, 1 or 2.
- R10: At start the target is clamped to [TGT_LO_EXT, TGT_HI] when wide_range is high, and to [TGT_LO, TGT_HI] otherwise (5, 31 and 148.5 MHz).
- R11: If no candidate exists, done rises with no_solution high and sel_err all ones.
- R12: start is ignored while busy is high. done stays high from the end of a search until the next accepted start.
- R13: After reset, busy, done and no_solution are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (accepted only in IDLE) |
| target_freq | input | W | Requested output frequency |
| wide_range | input | 1 | Selects the lower 5 MHz target floor |
| dot_only | input | 1 | Omit the divide-by-seven stage |
| ref0_freq | input | W | Reference 0 frequency |
| ref1_freq | input | W | Reference 1 frequency |
| ref2_freq | input | W | Reference 2 frequency |
| ref_valid | input | 3 | Per-reference valid bits, bit k for reference k |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result available |
| no_solution | output | 1 | Search ended without any candidate |
| sel_src | output | 2 | Index of the winning reference |
| sel_m | output | M_W | Chosen pre-divider M |
| sel_n | output | N_W | Chosen multiplier N |
| sel_e | output | E_W | Chosen post-divider exponent E |
| sel_div | output | W | Chosen output divider DIV |
| sel_err | output | W | Absolute error of the chosen setting |

## Verification
The bench builds the block with W = 22 and every limit parameter given in kHz instead of Hz. The search space is unchanged, while each divide shrinks from 32 to 22 cycles. This keeps full searches over one or three references short enough that the bench can run random reference and target mixes and still compare every output field against a bench-side search model. The same scaling puts the exact bounds 12000 and 192000 and the targets at and beyond both clamp limits within reach. So are exact-hit cases, where the latency bound shows the early stop.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_SRC,
        S_MLO,
        S_MHI,
        S_MCHK,
        S_PFD,
        S_NLO,
        S_NHI,
        S_NCHK,
        S_EINIT,
        S_ECHK,
        S_SEV,
        S_RND,
        S_OUT,
        S_CMP,
        S_DONE
    } srch_state_t;

    localparam int unsigned NUM_REFS = 3;
    localparam int unsigned SRC_W    = 2;

    typedef logic [SRC_W-1:0] src_idx_t;

endpackage

// File: rtl/pll_search_div.sv
module pll_search_div #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int unsigned CNT_W = $clog2(W + 1);

    logic [W-1:0]     quo_q;
    logic [W-1:0]     rem_q;
    logic [W-1:0]     dsr_q;
    logic [W-1:0]     dvd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [W:0]       trial;

    assign trial = {rem_q, quo_q[W-1]} - {1'b0, dsr_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
            dvd_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !busy_q) begin
                quo_q  <= dividend;
                rem_q  <= '0;
                dsr_q  <= divisor;
                dvd_q  <= dividend;
                cnt_q  <= CNT_W'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= {rem_q[W-2:0], quo_q[W-1]};
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign quotient = quo_q;

    // R6: every quotient handed back satisfies the division identity
    p_div_identity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ((({{W{1'b0}}, quo_q} * {{W{1'b0}}, dsr_q}) + {{W{1'b0}}, rem_q})
                    == {{W{1'b0}}, dvd_q}) && (rem_q < dsr_q));

endmodule

// File: rtl/pll_search_clamp.sv
module pll_search_clamp #(
    parameter int unsigned W      = 32,
    parameter longint      LO_EXT = 64'd5_000_000,
    parameter longint      LO_STD = 64'd31_000_000,
    parameter longint      HI     = 64'd148_500_000
) (
    input  logic [W-1:0] raw_freq,
    input  logic         wide,
    output logic [W-1:0] clamped
);
    localparam logic [W-1:0] LO_EXT_W = LO_EXT[W-1:0];
    localparam logic [W-1:0] LO_STD_W = LO_STD[W-1:0];
    localparam logic [W-1:0] HI_W     = HI[W-1:0];

    logic [W-1:0] floor_sel;

    always_comb begin
        floor_sel = wide ? LO_EXT_W : LO_STD_W;
        if (raw_freq < floor_sel)
            clamped = floor_sel;
        else if (raw_freq > HI_W)
            clamped = HI_W;
        else
            clamped = raw_freq;
    end

endmodule

// File: rtl/pll_search_best.sv
module pll_search_best
    import pll_search_pkg::*;
#(
    parameter int unsigned W   = 32,
    parameter int unsigned M_W = 4,
    parameter int unsigned N_W = 7,
    parameter int unsigned E_W = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           init,
    input  logic           eval,
    input  logic [M_W-1:0] cand_m,
    input  logic [N_W-1:0] cand_n,
    input  logic [E_W-1:0] cand_e,
    input  logic [W-1:0]   cand_div,
    input  src_idx_t       cand_src,
    input  logic [W-1:0]   cand_err,
    output logic           better,
    output logic           found,
    output logic [M_W-1:0] best_m,
    output logic [N_W-1:0] best_n,
    output logic [E_W-1:0] best_e,
    output logic [W-1:0]   best_div,
    output src_idx_t       best_src,
    output logic [W-1:0]   best_err
);
    assign better = cand_err < best_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            found    <= 1'b0;
            best_m   <= '0;
            best_n   <= '0;
            best_e   <= '0;
            best_div <= '0;
            best_src <= '0;
            best_err <= '1;
        end else if (init) begin
            found    <= 1'b0;
            best_m   <= '0;
            best_n   <= '0;
            best_e   <= '0;
            best_div <= '0;
            best_src <= '0;
            best_err <= '1;
        end else if (eval && better) begin
            found    <= 1'b1;
            best_m   <= cand_m;
            best_n   <= cand_n;
            best_e   <= cand_e;
            best_div <= cand_div;
            best_src <= cand_src;
            best_err <= cand_err;
        end
    end

    // R7: within a search the stored error never grows
    p_err_monotone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !init |=> best_err <= $past(best_err));

endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
    import pll_search_pkg::*;
#(
    parameter int unsigned W          = 32,
    parameter longint      FIN_MIN    = 64'd12_000_000,
    parameter longint      FIN_MAX    = 64'd192_000_000,
    parameter longint      PFD_MIN    = 64'd12_000_000,
    parameter longint      PFD_MAX    = 64'd24_000_000,
    parameter longint      VCO_MIN    = 64'd900_000_000,
    parameter longint      VCO_MAX    = 64'd1_800_000_000,
    parameter longint      E0_MAX     = 64'd1_039_500_000,
    parameter longint      TGT_LO_EXT = 64'd5_000_000,
    parameter longint      TGT_LO     = 64'd31_000_000,
    parameter longint      TGT_HI     = 64'd148_500_000,
    parameter int unsigned M_LIM      = 8,
    parameter int unsigned N_LO       = 60,
    parameter int unsigned N_HI       = 120,
    parameter int unsigned E_CNT      = 3,
    parameter int unsigned BIT_DIV    = 7,
    localparam int unsigned M_W       = $clog2(M_LIM + 2),
    localparam int unsigned N_W       = $clog2(N_HI + 1),
    localparam int unsigned E_W       = $clog2(E_CNT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   target_freq,
    input  logic           wide_range,
    input  logic           dot_only,
    input  logic [W-1:0]   ref0_freq,
    input  logic [W-1:0]   ref1_freq,
    input  logic [W-1:0]   ref2_freq,
    input  logic [2:0]     ref_valid,
    output logic           busy,
    output logic           done,
    output logic           no_solution,
    output logic [1:0]     sel_src,
    output logic [M_W-1:0] sel_m,
    output logic [N_W-1:0] sel_n,
    output logic [E_W-1:0] sel_e,
    output logic [W-1:0]   sel_div,
    output logic [W-1:0]   sel_err
);
    localparam logic [W-1:0]   FIN_MIN_W  = FIN_MIN[W-1:0];
    localparam logic [W-1:0]   FIN_MAX_W  = FIN_MAX[W-1:0];
    localparam logic [W-1:0]   PFD_MIN_W  = PFD_MIN[W-1:0];
    localparam logic [W-1:0]   PFD_MAX_W  = PFD_MAX[W-1:0];
    localparam logic [W-1:0]   VCO_MIN_W  = VCO_MIN[W-1:0];
    localparam logic [W-1:0]   VCO_MAX_W  = VCO_MAX[W-1:0];
    localparam logic [W-1:0]   E0_MAX_W   = E0_MAX[W-1:0];
    localparam logic [W-1:0]   TGT_LO_X_W = TGT_LO_EXT[W-1:0];
    localparam logic [W-1:0]   TGT_HI_W   = TGT_HI[W-1:0];
    localparam logic [W-1:0]   M_LIM_W    = W'(M_LIM);
    localparam logic [W-1:0]   N_LO_W     = W'(N_LO);
    localparam logic [W-1:0]   N_HI_W     = W'(N_HI);
    localparam logic [W-1:0]   BIT_DIV_W  = W'(BIT_DIV);
    localparam logic [E_W-1:0] E_END      = E_W'(E_CNT);
    localparam src_idx_t       SRC_END    = SRC_W'(NUM_REFS);

    srch_state_t state_q, state_d;

    logic [W-1:0]   tgt_q, fin_q, fpfd_q, fvco_q, fout_q, div_q, err_q;
    logic [M_W-1:0] m_q, m_top_q;
    logic [N_W-1:0] n_q, n_top_q;
    logic [E_W-1:0] e_q;
    src_idx_t       src_q;
    logic           dot_q, done_q, waiting_q;

    logic [W-1:0]   tgt_clamped, cur_ref;
    logic           cur_ok, is_div;
    logic [W-1:0]   dvd, dsr, quo;
    logic           div_go, div_busy, div_done;
    logic           init_best, eval_best, better, found;
    logic [W-1:0]   best_div, best_err;
    logic [M_W-1:0] best_m;
    logic [N_W-1:0] best_n;
    logic [E_W-1:0] best_e;
    src_idx_t       best_src;
    logic [W-1:0]   shifted;

    pll_search_clamp #(
        .W(W), .LO_EXT(TGT_LO_EXT), .LO_STD(TGT_LO), .HI(TGT_HI)
    ) u_clamp (
        .raw_freq(target_freq),
        .wide    (wide_range),
        .clamped (tgt_clamped)
    );

    always_comb begin
        unique case (src_q)
            2'd0:    cur_ref = ref0_freq;
            2'd1:    cur_ref = ref1_freq;
            2'd2:    cur_ref = ref2_freq;
            default: cur_ref = '0;
        endcase
    end

    assign cur_ok  = (src_q != SRC_END) && ref_valid[src_q] &&
                     (cur_ref >= FIN_MIN_W) && (cur_ref <= FIN_MAX_W);
    assign shifted = fvco_q >> e_q;

    // divider operand selection
    always_comb begin
        is_div = 1'b1;
        dvd    = '0;
        dsr    = W'(1);
        unique case (state_q)
            S_MLO: begin dvd = fin_q + PFD_MAX_W - W'(1);    dsr = PFD_MAX_W; end
            S_MHI: begin dvd = fin_q;                        dsr = PFD_MIN_W; end
            S_PFD: begin dvd = fin_q;                        dsr = W'(m_q);   end
            S_NLO: begin dvd = VCO_MIN_W + fpfd_q - W'(1);   dsr = fpfd_q;    end
            S_NHI: begin dvd = VCO_MAX_W;                    dsr = fpfd_q;    end
            S_SEV: begin dvd = shifted;                      dsr = BIT_DIV_W; end
            S_RND: begin dvd = fout_q + (tgt_q >> 1);        dsr = tgt_q;     end
            S_OUT: begin dvd = fout_q;                       dsr = div_q;     end
            default: is_div = 1'b0;
        endcase
    end

    assign div_go = is_div && !waiting_q && !div_busy;

    pll_search_div #(.W(W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (div_go),
        .dividend(dvd),
        .divisor (dsr),
        .busy    (div_busy),
        .done    (div_done),
        .quotient(quo)
    );

    assign init_best = (state_q == S_IDLE) && start;
    assign eval_best = (state_q == S_CMP);

    pll_search_best #(.W(W), .M_W(M_W), .N_W(N_W), .E_W(E_W)) u_best (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (init_best),
        .eval    (eval_best),
        .cand_m  (m_q),
        .cand_n  (n_q),
        .cand_e  (e_q),
        .cand_div(div_q),
        .cand_src(src_q),
        .cand_err(err_q),
        .better  (better),
        .found   (found),
        .best_m  (best_m),
        .best_n  (best_n),
        .best_e  (best_e),
        .best_div(best_div),
        .best_src(best_src),
        .best_err(best_err)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_SRC;
            S_SRC: begin
                if (src_q == SRC_END) state_d = S_DONE;
                else if (cur_ok)      state_d = S_MLO;
            end
            S_MLO:   if (div_done) state_d = S_MHI;
            S_MHI:   if (div_done) state_d = S_MCHK;
            S_MCHK:  state_d = (m_q > m_top_q) ? S_SRC : S_PFD;
            S_PFD:   if (div_done) state_d = S_NLO;
            S_NLO:   if (div_done) state_d = S_NHI;
            S_NHI:   if (div_done) state_d = S_NCHK;
            S_NCHK:  state_d = (n_q >= n_top_q) ? S_MCHK : S_EINIT;
            S_EINIT: state_d = S_ECHK;
            S_ECHK: begin
                if (e_q == E_END) state_d = S_NCHK;
                else if (dot_q)   state_d = S_RND;
                else              state_d = S_SEV;
            end
            S_SEV:   if (div_done) state_d = S_RND;
            S_RND:   if (div_done) state_d = S_OUT;
            S_OUT:   if (div_done) state_d = S_CMP;
            S_CMP:   state_d = (better && err_q == '0) ? S_DONE : S_ECHK;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q     <= '0;
            fin_q     <= '0;
            fpfd_q    <= '0;
            fvco_q    <= '0;
            fout_q    <= '0;
            div_q     <= '0;
            err_q     <= '0;
            m_q       <= '0;
            m_top_q   <= '0;
            n_q       <= '0;
            n_top_q   <= '0;
            e_q       <= '0;
            src_q     <= '0;
            dot_q     <= 1'b0;
            done_q    <= 1'b0;
            waiting_q <= 1'b0;
        end else begin
            if (div_go)        waiting_q <= 1'b1;
            else if (div_done) waiting_q <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    tgt_q  <= tgt_clamped;
                    dot_q  <= dot_only;
                    src_q  <= '0;
                    done_q <= 1'b0;
                end
                S_SRC: if (src_q != SRC_END) begin
                    if (cur_ok) fin_q <= cur_ref;
                    else        src_q <= src_q + 1'b1;
                end
                S_MLO: if (div_done)
                    m_q <= (quo == '0) ? M_W'(1) :
                           (quo > M_LIM_W) ? M_W'(M_LIM + 1) : quo[M_W-1:0];
                S_MHI: if (div_done)
                    m_top_q <= (quo > M_LIM_W) ? M_W'(M_LIM) : quo[M_W-1:0];
                S_MCHK: if (m_q > m_top_q) src_q <= src_q + 1'b1;
                S_PFD: if (div_done) fpfd_q <= quo;
                S_NLO: if (div_done)
                    n_q <= (quo < N_LO_W) ? N_W'(N_LO) :
                           (quo > N_HI_W) ? N_W'(N_HI) : quo[N_W-1:0];
                S_NHI: if (div_done)
                    n_top_q <= (quo > N_HI_W) ? N_W'(N_HI) : quo[N_W-1:0];
                S_NCHK: begin
                    if (n_q >= n_top_q) m_q <= m_q + 1'b1;
                    else fvco_q <= fpfd_q * W'(n_q);
                end
                S_EINIT: e_q <= (fvco_q > E0_MAX_W) ? E_W'(1) : E_W'(0);
                S_ECHK: begin
                    if (e_q == E_END) n_q <= n_q + 1'b1;
                    else if (dot_q)   fout_q <= shifted;
                end
                S_SEV: if (div_done) fout_q <= quo;
                S_RND: if (div_done) div_q <= (quo == '0) ? W'(1) : quo;
                S_OUT: if (div_done)
                    err_q <= (quo >= tgt_q) ? (quo - tgt_q) : (tgt_q - quo);
                S_CMP:  e_q <= e_q + 1'b1;
                S_DONE: done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != S_IDLE);
        done        = done_q;
        no_solution = done_q && !found;
        sel_src     = best_src;
        sel_m       = best_m;
        sel_n       = best_n;
        sel_e       = best_e;
        sel_div     = best_div;
        sel_err     = best_err;
    end

    // R12: a start seen during a search leaves the latched request untouched
    p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(tgt_q) && $stable(dot_q)));

    // R10: the latched target always lies inside the widest legal window
    p_tgt_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tgt_q >= TGT_LO_X_W && tgt_q <= TGT_HI_W));

    // R2: the comparison frequency never drops below its floor
    p_m_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PFD) |-> (m_q != '0 && (W'(m_q) * PFD_MIN_W) <= fin_q));

    // R3: every evaluated VCO frequency lies inside the VCO window
    p_vco_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EINIT) |-> (fvco_q >= VCO_MIN_W && fvco_q < VCO_MAX_W));

    // R4: exponent 0 is never evaluated above the bypass limit
    p_e0_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ECHK && e_q == '0) |-> (fvco_q <= E0_MAX_W));

    // R2, R3, R4, R6: a reported result has fields within their ranges
    p_fields_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_solution) |-> (sel_m != '0 && W'(sel_m) <= M_LIM_W &&
            W'(sel_n) >= N_LO_W && W'(sel_n) < N_HI_W &&
            sel_e < E_END && sel_div != '0));

    // R11: an empty search reports the all-ones error
    p_nosol_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_solution) |-> (sel_err == '1));

endmodule

// File: tb/sim_pll_param_search.sv
module sim_pll_param_search;
    localparam int W = 22;
    localparam longint ALL1 = (64'd1 << W) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n, start, wide_range, dot_only;
    logic [W-1:0] target_freq, ref0_freq, ref1_freq, ref2_freq;
    logic [2:0]   ref_valid;
    logic         busy, done, no_solution;
    logic [1:0]   sel_src;
    logic [3:0]   sel_m;
    logic [6:0]   sel_n;
    logic [1:0]   sel_e;
    logic [W-1:0] sel_div, sel_err;

    int checks = 0;
    int errors = 0;

    pll_param_search #(
        .W(W), .FIN_MIN(12000), .FIN_MAX(192000), .PFD_MIN(12000), .PFD_MAX(24000),
        .VCO_MIN(900000), .VCO_MAX(1800000), .E0_MAX(1039500),
        .TGT_LO_EXT(5000), .TGT_LO(31000), .TGT_HI(148500)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .target_freq(target_freq),
        .wide_range(wide_range), .dot_only(dot_only), .ref0_freq(ref0_freq),
        .ref1_freq(ref1_freq), .ref2_freq(ref2_freq), .ref_valid(ref_valid),
        .busy(busy), .done(done), .no_solution(no_solution), .sel_src(sel_src),
        .sel_m(sel_m), .sel_n(sel_n), .sel_e(sel_e), .sel_div(sel_div), .sel_err(sel_err)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // search model written from the requirements
    task automatic model(input longint tin, input bit wide, input bit dot,
                         input longint f0, input longint f1, input longint f2,
                         input bit [2:0] v, output bit fnd, output longint bm,
                         output longint bn, output longint be, output longint bd,
                         output longint bs, output longint berr);
        longint t, lo, fin, mlo, mhi, fpfd, nlo, nhi, fvco, fo, d, q, diff;
        bit stop;
        lo = wide ? 5000 : 31000;
        t = (tin < lo) ? lo : (tin > 148500 ? 148500 : tin);
        fnd = 0; bm = 0; bn = 0; be = 0; bd = 0; bs = 0; berr = ALL1; stop = 0;
        for (int s = 0; s < 3 && !stop; s++) begin
            fin = (s == 0) ? f0 : (s == 1) ? f1 : f2;
            if (!v[s] || fin < 12000 || fin > 192000) continue;
            mlo = (fin + 23999) / 24000; if (mlo < 1) mlo = 1;
            mhi = fin / 12000;           if (mhi > 8) mhi = 8;
            for (longint m = mlo; m <= mhi && !stop; m++) begin
                fpfd = fin / m;
                nlo = (900000 + fpfd - 1) / fpfd; if (nlo < 60) nlo = 60;
                nhi = 1800000 / fpfd;             if (nhi > 120) nhi = 120;
                for (longint n = nlo; n < nhi && !stop; n++) begin
                    fvco = fpfd * n;
                    for (longint e = (fvco > 1039500) ? 1 : 0; e < 3 && !stop; e++) begin
                        fo = fvco >> e;
                        if (!dot) fo = fo / 7;
                        d = (fo + t / 2) / t; if (d < 1) d = 1;
                        q = fo / d;
                        diff = (q >= t) ? q - t : t - q;
                        if (diff < berr) begin
                            berr = diff; bm = m; bn = n; be = e; bd = d; bs = s; fnd = 1;
                            if (diff == 0) stop = 1;
                        end
                    end
                end
            end
        end
    endtask

    task automatic launch(input longint t, input bit wide, input bit dot,
                          input longint f0, input longint f1, input longint f2,
                          input bit [2:0] v);
        target_freq = W'(t); wide_range = wide; dot_only = dot;
        ref0_freq = W'(f0); ref1_freq = W'(f1); ref2_freq = W'(f2); ref_valid = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic compare(input string tag, input longint t, input bit wide, input bit dot,
                           input longint f0, input longint f1, input longint f2,
                           input bit [2:0] v);
        bit fnd;
        longint bm, bn, be, bd, bs, berr;
        model(t, wide, dot, f0, f1, f2, v, fnd, bm, bn, be, bd, bs, berr);
        chk({tag, " R11 no_solution"}, no_solution, !fnd);
        chk({tag, " R6 err"}, sel_err, berr);
        if (fnd) begin
            chk({tag, " R9 src"}, sel_src, bs);
            chk({tag, " R2 m"}, sel_m, bm);
            chk({tag, " R3 n"}, sel_n, bn);
            chk({tag, " R4 e"}, sel_e, be);
            chk({tag, " R6 div"}, sel_div, bd);
        end
    endtask

    task automatic run(input string tag, input longint t, input bit wide, input bit dot,
                       input longint f0, input longint f1, input longint f2,
                       input bit [2:0] v, output int cyc);
        launch(t, wide, dot, f0, f1, f2, v);
        wait_done(cyc);
        compare(tag, t, wide, dot, f0, f1, f2, v);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog: actual done=0 expected done=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        void'($urandom(32'd4242));
        rst_n = 1'b0; start = 1'b0; wide_range = 1'b0; dot_only = 1'b0;
        target_freq = '0; ref0_freq = '0; ref1_freq = '0; ref2_freq = '0; ref_valid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 busy after reset", busy, 0);
        chk("R13 done after reset", done, 0);
        chk("R13 no_solution after reset", no_solution, 0);

        // exact hit in dot-only mode: must stop almost at once
        run("exact_dot", 60000, 0, 1, 24000, 0, 0, 3'b001, cyc);
        chk("R8 early stop latency", (cyc < 400), 1);
        chk("R8 zero error", sel_err, 0);

        // same reference with the divide-by-seven stage
        run("exact_seven R5", 60000, 0, 0, 24000, 0, 0, 3'b001, cyc);
        chk("R5 seven-stage exact error", sel_err, 0);
        chk("R5 seven-stage e", sel_e, 1);

        // equal references: first one kept on ties
        run("tie R7", 71111, 0, 0, 180000, 180000, 180000, 3'b111, cyc);
        chk("R7 first source kept", sel_src, 0);

        // reference 0 invalid, 1 and 2 identical exact: index 1 wins
        run("order R9", 60000, 0, 1, 24000, 24000, 24000, 3'b110, cyc);
        chk("R9 winner index", sel_src, 1);

        // range bounds: 11999 and 192001 skipped, 12000 accepted
        run("bounds R1", 50000, 0, 1, 11999, 192001, 12000, 3'b111, cyc);
        chk("R1 in-range bound used", sel_src, 2);

        // no usable reference at all
        run("none R11", 60000, 0, 0, 24000, 24000, 24000, 3'b000, cyc);
        chk("R11 no_solution flag", no_solution, 1);
        chk("R11 err all ones", sel_err, ALL1);
        run("outside R1", 60000, 0, 0, 5000, 200000, 11999, 3'b111, cyc);
        chk("R1 all out of range", no_solution, 1);

        // target clamping
        run("clamp_std R10", 1000, 0, 0, 190000, 0, 0, 3'b001, cyc);
        run("clamp_wide R10", 1000, 1, 1, 190000, 0, 0, 3'b001, cyc);
        run("clamp_hi R10", 300000, 1, 0, 190000, 0, 0, 3'b001, cyc);

        // start during a search is ignored
        launch(77777, 0, 0, 185000, 0, 0, 3'b001);
        repeat (50) @(negedge clk);
        target_freq = W'(40000); dot_only = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R12 still busy after ignored start", busy, 1);
        wait_done(cyc);
        compare("ignored_start R12", 77777, 0, 0, 185000, 0, 0, 3'b001);
        repeat (5) @(negedge clk);
        chk("R12 done held", done, 1);
        chk("R12 idle after done", busy, 0);

        // random single-reference searches
        for (int i = 0; i < 6; i++) begin
            longint f, t;
            bit wd, dt;
            int k;
            bit [2:0] vv;
            f  = 96000 + ($urandom % 96001);
            t  = 2000 + ($urandom % 160000);
            wd = $urandom % 2;
            dt = $urandom % 2;
            k  = $urandom % 3;
            vv = 3'b001 << k;
            run($sformatf("rand%0d R2 R3 R4 R5 R6", i), t, wd, dt,
                (k == 0) ? f : 64'd0, (k == 1) ? f : 64'd0, (k == 2) ? f : 64'd0, vv, cyc);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule